// File: doc/BRIEF.md
# Energy Pulse Output Generator

This block turns signed, per-sample energy quantities into pulse trains on three output pins. Each output-word-rate sample is marked by a single-cycle strobe. On every strobe, each of four quantities (active, apparent, reactive and wideband reactive energy) adds its magnitude, scaled by a fractional rate factor, into its own phase accumulator. When an accumulator reaches half of its full scale, it emits a pulse. The pulse then stays high for a programmable number of sample periods. The accumulator keeps the remainder, so the long-run pulse frequency is the rate factor times half the sample rate times the magnitude of the value.

A no-load threshold silences small active and reactive quantities. Three 2-bit mode fields route pulse trains or steady-state status signals to the three pins. One code of the second pin's field switches both the first and second pins to an alternate table. In that table a single selected quantity is split by direction. The third pin then follows a separate, shorter table.

Top module: `epulse_gen`

## Requirements
- R1: While the reset input is low, all three pins are low and every accumulator and pulse timer is cleared.
- R2: Values are Q1.15 two's complement and the rate factor is unsigned Q0.16. After reset, M strobes with constant value v and rate r yield exactly floor(M·|v|·r / 2^32) pulses on the pin carrying that quantity.
- R3: Each pulse stays high for W strobe periods, where W is the width input. A width of 0 behaves as 1.
- R4: A no-load threshold T applies to active, reactive and wideband reactive quantities. T is an unsigned magnitude in the same Q1.15 units. When |v| < T, the quantity produces no pulses and its sign reads as non-negative. The apparent quantity is never silenced.
- R5: When the alternate table is not selected, the second-pin mode sets the second pin. Code 0 gives the active sign (1 = negative). Code 1 gives apparent pulses. Code 2 gives the channel-in-use flag. Code 3 selects the alternate table.
- R6: When the alternate table is not selected, the third-pin mode sets the third pin. Code 0 gives reactive pulses. Code 1 gives power-fail status. Code 2 gives voltage sign. Code 3 gives apparent pulses.
- R7: With the second-pin mode at 3, the first-pin mode picks one quantity: 0 active, 1 apparent, 2 reactive, 3 wideband reactive. Its pulses go to pin 1 when the value was non-negative at the crossing, and to pin 2 when it was negative.
- R8: With the second-pin mode at 3, the third-pin mode sets the third pin. Code 0 gives power-fail status. Code 1 gives the sign of the selected quantity. Codes 2 and 3 hold the pin low.
- R9: A pin carrying a steady-state signal follows its input one clock later. It is unaffected by the rate factor, the width and the strobe.
- R10: With all mode fields at 0, pin 1 carries active pulses, pin 2 the active sign and pin 3 reactive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe per output sample |
| act_val | input | VAL_W | Active energy per sample, signed fraction |
| app_val | input | VAL_W | Apparent energy per sample, signed fraction |
| rea_val | input | VAL_W | Reactive energy per sample, signed fraction |
| wrea_val | input | VAL_W | Wideband reactive energy per sample, signed fraction |
| rate_k | input | RATE_W | Unsigned fractional pulse-rate factor |
| width_n | input | PW_W | Pulse width in sample periods |
| noload_min | input | VAL_W | No-load magnitude threshold |
| e1_mode | input | 2 | First-pin mode / alternate quantity select |
| e2_mode | input | 2 | Second-pin mode |
| e3_mode | input | 2 | Third-pin mode |
| chan_in_use | input | 1 | Energy channel in use flag |
| volt_sign | input | 1 | Voltage sign |
| pwr_fail | input | 1 | Power-fail monitor status |
| pin_e1 | output | 1 | First output pin |
| pin_e2 | output | 1 | Second output pin |
| pin_e3 | output | 1 | Third output pin |

## Verification
The bench sweeps magnitudes up to the most negative code at rates up to the largest factor and counts pulses over a fixed run. An accumulator that dropped its remainder or compared against the wrong threshold would miss the exact floor count. A magnitude taken wrongly from negative values would also miss it. It drives magnitudes just below, at and above the no-load threshold, so an off-by-one compare or silencing of the apparent quantity shows up as a count or sign error. Pulse widths 0, 1, 3 and 5 are timed in clocks, which catches a zero width that yields no pulse or a width of one period too many. Every code of every mode field is walked, including the direction split and the unused alternate codes, so a swapped table entry or a stray pulse on a steady pin is reported.

// File: rtl/epg_pkg.sv
package epg_pkg;
  localparam int QN      = 4;
  localparam int IDX_ACT = 0;
  localparam int IDX_APP = 1;
  localparam int IDX_REA = 2;
  localparam int IDX_WRE = 3;

  typedef enum logic [1:0] {
    P2_SIGN = 2'd0,
    P2_APP  = 2'd1,
    P2_CHAN = 2'd2,
    P2_ALT  = 2'd3
  } p2_mode_e;

  typedef enum logic [1:0] {
    P3_REA = 2'd0,
    P3_PF  = 2'd1,
    P3_VS  = 2'd2,
    P3_APP = 2'd3
  } p3_mode_e;

  typedef enum logic [1:0] {
    P3A_PF   = 2'd0,
    P3A_SIGN = 2'd1,
    P3A_OFF2 = 2'd2,
    P3A_OFF3 = 2'd3
  } p3_alt_e;
endpackage

// File: rtl/epg_accum.sv
module epg_accum #(
  parameter int MAG_W  = 16,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [MAG_W-1:0]  mag,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  localparam int PROD_W = MAG_W + RATE_W;
  localparam int ACC_W  = PROD_W + 1;

  logic [PROD_W-1:0] inc;
  logic [ACC_W-1:0]  sum;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;

  always_comb begin
    inc   = PROD_W'(mag) * PROD_W'(rate);
    sum   = acc_q + {1'b0, inc};
    fire  = strobe & sum[ACC_W-1];
    acc_d = acc_q;
    if (strobe) begin
      acc_d = {1'b0, sum[ACC_W-2:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  // R2: the kept remainder always sits below the firing threshold
  assert_rem_below_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !acc_q[ACC_W-1]);
endmodule

// File: rtl/epg_width.sv
module epg_width #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic            fire,
  input  logic            sign_in,
  input  logic [PW_W-1:0] width,
  output logic            pulse,
  output logic            neg
);
  logic [PW_W-1:0] cnt_q;
  logic [PW_W-1:0] cnt_d;
  logic            pulse_q;
  logic            pulse_d;
  logic            neg_q;
  logic            neg_d;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = pulse_q;
    neg_d   = neg_q;
    if (strobe) begin
      if (fire) begin
        pulse_d = 1'b1;
        cnt_d   = (width == '0) ? PW_W'(1) : width;
        neg_d   = sign_in;
      end else if (pulse_q) begin
        if (cnt_q <= PW_W'(1)) begin
          pulse_d = 1'b0;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - PW_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      neg_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      neg_q   <= neg_d;
    end
  end

  assign pulse = pulse_q;
  assign neg   = neg_q;

  // R3: pulse edges only follow a sample strobe
  assert_rise_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(strobe));
  assert_fall_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> $past(strobe));
endmodule

// File: rtl/epg_pinmux.sv
module epg_pinmux
  import epg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    e1m,
  input  logic [1:0]    e2m,
  input  logic [1:0]    e3m,
  input  logic [QN-1:0] pulse,
  input  logic [QN-1:0] neg,
  input  logic [QN-1:0] sgn,
  input  logic          chan_use,
  input  logic          vsign,
  input  logic          pfail,
  output logic          pin1,
  output logic          pin2,
  output logic          pin3
);
  p2_mode_e p2;
  p3_mode_e p3;
  p3_alt_e  p3a;
  logic     alt;
  logic     p1_d;
  logic     p2_d;
  logic     p3_d;
  logic     pin1_q;
  logic     pin2_q;
  logic     pin3_q;

  always_comb begin
    p2  = p2_mode_e'(e2m);
    p3  = p3_mode_e'(e3m);
    p3a = p3_alt_e'(e3m);
    alt = (p2 == P2_ALT);
    p1_d = 1'b0;
    p2_d = 1'b0;
    p3_d = 1'b0;
    if (alt) begin
      p1_d = pulse[e1m] & ~neg[e1m];
      p2_d = pulse[e1m] &  neg[e1m];
      case (p3a)
        P3A_PF:   p3_d = pfail;
        P3A_SIGN: p3_d = sgn[e1m];
        default:  p3_d = 1'b0;
      endcase
    end else begin
      p1_d = pulse[IDX_ACT];
      case (p2)
        P2_SIGN: p2_d = sgn[IDX_ACT];
        P2_APP:  p2_d = pulse[IDX_APP];
        default: p2_d = chan_use;
      endcase
      case (p3)
        P3_REA:  p3_d = pulse[IDX_REA];
        P3_PF:   p3_d = pfail;
        P3_VS:   p3_d = vsign;
        default: p3_d = pulse[IDX_APP];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin1_q <= 1'b0;
      pin2_q <= 1'b0;
      pin3_q <= 1'b0;
    end else begin
      pin1_q <= p1_d;
      pin2_q <= p2_d;
      pin3_q <= p3_d;
    end
  end

  assign pin1 = pin1_q;
  assign pin2 = pin2_q;
  assign pin3 = pin3_q;

  // R8: unused alternate third-pin codes keep the pin low
  assert_alt_unused_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (e2m == 2'd3 && e3m[1]) |=> !pin3_q);
  // R9: channel-in-use flag passes through with one clock of latency
  assert_chan_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (e2m == 2'd2) |=> (pin2_q == $past(chan_use)));
  // R6: power-fail status passes through with one clock of latency
  assert_pf_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (e2m != 2'd3 && e3m == 2'd1) |=> (pin3_q == $past(pfail)));
endmodule

// File: rtl/epulse_gen.sv
module epulse_gen
  import epg_pkg::*;
#(
  parameter int VAL_W  = 16,
  parameter int RATE_W = 16,
  parameter int PW_W   = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              smp_stb,
  input  logic [VAL_W-1:0]  act_val,
  input  logic [VAL_W-1:0]  app_val,
  input  logic [VAL_W-1:0]  rea_val,
  input  logic [VAL_W-1:0]  wrea_val,
  input  logic [RATE_W-1:0] rate_k,
  input  logic [PW_W-1:0]   width_n,
  input  logic [VAL_W-1:0]  noload_min,
  input  logic [1:0]        e1_mode,
  input  logic [1:0]        e2_mode,
  input  logic [1:0]        e3_mode,
  input  logic              chan_in_use,
  input  logic              volt_sign,
  input  logic              pwr_fail,
  output logic              pin_e1,
  output logic              pin_e2,
  output logic              pin_e3
);
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n = rs_q[1];

  logic [QN-1:0][VAL_W-1:0] val;
  logic [QN-1:0][VAL_W-1:0] mag;
  logic [QN-1:0]            sgn;
  logic [QN-1:0]            fire;
  logic [QN-1:0]            pulse;
  logic [QN-1:0]            neg;

  assign val[IDX_ACT] = act_val;
  assign val[IDX_APP] = app_val;
  assign val[IDX_REA] = rea_val;
  assign val[IDX_WRE] = wrea_val;

  for (genvar q = 0; q < QN; q++) begin : g_q
    localparam bit CAN_MUTE = (q != IDX_APP);
    logic [VAL_W-1:0] raw_mag;
    logic             mute;

    assign raw_mag = val[q][VAL_W-1] ? (~val[q] + VAL_W'(1)) : val[q];
    assign mute    = CAN_MUTE && (raw_mag < noload_min);
    assign mag[q]  = mute ? '0 : raw_mag;
    assign sgn[q]  = val[q][VAL_W-1] & ~mute;

    epg_accum #(.MAG_W(VAL_W), .RATE_W(RATE_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (smp_stb),
      .mag    (mag[q]),
      .rate   (rate_k),
      .fire   (fire[q])
    );

    epg_width #(.PW_W(PW_W)) u_wid (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (smp_stb),
      .fire    (fire[q]),
      .sign_in (sgn[q]),
      .width   (width_n),
      .pulse   (pulse[q]),
      .neg     (neg[q])
    );

    if (CAN_MUTE) begin : g_mute_chk
      // R4: a muted quantity never starts a pulse
      assert_muted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb && mute && !pulse[q]) |=> !pulse[q]);
    end
  end

  epg_pinmux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .e1m      (e1_mode),
    .e2m      (e2_mode),
    .e3m      (e3_mode),
    .pulse    (pulse),
    .neg      (neg),
    .sgn      (sgn),
    .chan_use (chan_in_use),
    .vsign    (volt_sign),
    .pfail    (pwr_fail),
    .pin1     (pin_e1),
    .pin2     (pin_e2),
    .pin3     (pin_e3)
  );
endmodule

// File: tb/tb_epulse_gen.sv
module tb_epulse_gen;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [15:0] act_val = '0, app_val = '0, rea_val = '0, wrea_val = '0;
  logic [15:0] rate_k = '0;
  logic [7:0]  width_n = 8'd1;
  logic [15:0] noload_min = '0;
  logic [1:0]  e1_mode = '0, e2_mode = '0, e3_mode = '0;
  logic        chan_in_use = 1'b0, volt_sign = 1'b0, pwr_fail = 1'b0;
  logic        pin_e1, pin_e2, pin_e3;

  always #4 clk = ~clk;

  epulse_gen dut (
    .clk(clk), .arst_n(arst_n), .smp_stb(smp_stb),
    .act_val(act_val), .app_val(app_val), .rea_val(rea_val), .wrea_val(wrea_val),
    .rate_k(rate_k), .width_n(width_n), .noload_min(noload_min),
    .e1_mode(e1_mode), .e2_mode(e2_mode), .e3_mode(e3_mode),
    .chan_in_use(chan_in_use), .volt_sign(volt_sign), .pwr_fail(pwr_fail),
    .pin_e1(pin_e1), .pin_e2(pin_e2), .pin_e3(pin_e3)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint c_r1 = 0, c_r2 = 0, c_r3 = 0, c_h1 = 0;
  logic q1 = 1'b0, q2 = 1'b0, q3 = 1'b0;
  longint d1, d2, d3, dh;

  always @(negedge clk) begin
    if (pin_e1 && !q1) c_r1 <= c_r1 + 1;
    if (pin_e2 && !q2) c_r2 <= c_r2 + 1;
    if (pin_e3 && !q3) c_r3 <= c_r3 + 1;
    if (pin_e1) c_h1 <= c_h1 + 1;
    q1 <= pin_e1;
    q2 <= pin_e2;
    q3 <= pin_e3;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expn(input int m, input logic [15:0] v, input logic [15:0] r);
    longint mg = v[15] ? (65536 - longint'(v)) : longint'(v);
    return (longint'(m) * mg * longint'(r)) >>> 32;
  endfunction

  task automatic do_reset();
    @(negedge clk) arst_n = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input int m, input int tail);
    longint b1 = c_r1, b2 = c_r2, b3 = c_r3, bh = c_h1;
    repeat (m) begin
      @(negedge clk) smp_stb = 1'b1;
      @(negedge clk) smp_stb = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (tail) @(negedge clk);
    d1 = c_r1 - b1; d2 = c_r2 - b2; d3 = c_r3 - b3; dh = c_h1 - bh;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] vs [6];
    logic [15:0] rs [3];
    vs[0] = 16'h0100; vs[1] = 16'h1234; vs[2] = 16'h4000;
    vs[3] = 16'h7FFF; vs[4] = 16'hD000; vs[5] = 16'h8000;
    rs[0] = 16'h0800; rs[1] = 16'h3333; rs[2] = 16'hFFFF;

    // R1: pins low while reset is held, even with a negative active value
    act_val = 16'hC000; pwr_fail = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pins during reset", {pin_e1, pin_e2, pin_e3}, 0);
    pwr_fail = 1'b0;

    // R2 and R10: pulse count sweep in the default mode set
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 3; j++) begin
        act_val = vs[i]; rea_val = vs[i]; rate_k = rs[j];
        do_reset();
        run(200, 16);
        chk("R2 pin1 active count", d1, expn(200, vs[i], rs[j]));
        chk("R10 pin3 reactive count", d3, expn(200, vs[i], rs[j]));
      end
    end

    // R10: default second pin is the active sign
    act_val = 16'hE000; settle();
    chk("R10 pin2 active sign", pin_e2, 1);

    // R3: pulse width in sample periods, zero treated as one
    act_val = 16'h4000; rate_k = 16'h2000;
    for (int w = 0; w < 6; w++) begin
      if (w == 2 || w == 4) continue;
      width_n = 8'(w);
      do_reset();
      run(200, 4 * (w + 2));
      chk("R3 pulse count", d1, expn(200, 16'h4000, 16'h2000));
      chk("R3 high clocks", dh, expn(200, 16'h4000, 16'h2000) * ((w == 0) ? 1 : w) * 4);
    end
    width_n = 8'd1;

    // R4: no-load threshold
    noload_min = 16'h1000; rate_k = 16'hFFFF;
    act_val = 16'h0800; do_reset(); run(100, 8);
    chk("R4 muted active count", d1, 0);
    act_val = 16'h0FFF; do_reset(); run(100, 8);
    chk("R4 just below threshold count", d1, 0);
    act_val = 16'h1000; do_reset(); run(100, 8);
    chk("R4 at threshold count", d1, expn(100, 16'h1000, 16'hFFFF));
    act_val = 16'hF800; settle();
    chk("R4 muted sign reads non-negative", pin_e2, 0);
    app_val = 16'h0800; e2_mode = 2'd1; do_reset(); run(100, 8);
    chk("R4 apparent never muted", d2, expn(100, 16'h0800, 16'hFFFF));
    noload_min = 16'h0000;

    // R5: second pin table
    rate_k = 16'h4000; app_val = 16'h3000;
    e2_mode = 2'd1; do_reset(); run(150, 8);
    chk("R5 code1 apparent count", d2, expn(150, 16'h3000, 16'h4000));
    e2_mode = 2'd2; chan_in_use = 1'b1; settle();
    chk("R5 code2 channel flag high", pin_e2, 1);
    chan_in_use = 1'b0; settle();
    chk("R5 code2 channel flag low", pin_e2, 0);
    e2_mode = 2'd0; act_val = 16'hA000; settle();
    chk("R5 code0 sign negative", pin_e2, 1);
    act_val = 16'h2000; settle();
    chk("R5 code0 sign positive", pin_e2, 0);

    // R6: third pin table
    e3_mode = 2'd1; pwr_fail = 1'b1; settle();
    chk("R6 code1 power fail high", pin_e3, 1);
    pwr_fail = 1'b0; settle();
    chk("R6 code1 power fail low", pin_e3, 0);
    e3_mode = 2'd2; volt_sign = 1'b1; settle();
    chk("R6 code2 voltage sign", pin_e3, 1);
    volt_sign = 1'b0; settle();
    chk("R6 code2 voltage sign low", pin_e3, 0);
    e3_mode = 2'd3; do_reset(); run(150, 8);
    chk("R6 code3 apparent count", d3, expn(150, 16'h3000, 16'h4000));

    // R7: alternate table with direction split
    act_val = 16'h2000; app_val = 16'h3000; rea_val = 16'hD800; wrea_val = 16'hE800;
    e2_mode = 2'd3; e3_mode = 2'd0;
    for (int k = 0; k < 4; k++) begin
      logic [15:0] sv;
      sv = (k == 0) ? act_val : (k == 1) ? app_val : (k == 2) ? rea_val : wrea_val;
      e1_mode = 2'(k);
      do_reset(); run(150, 8);
      chk("R7 pin1 forward count", d1, sv[15] ? 0 : expn(150, sv, 16'h4000));
      chk("R7 pin2 reverse count", d2, sv[15] ? expn(150, sv, 16'h4000) : 0);
    end

    // R8: alternate third pin table
    pwr_fail = 1'b1; volt_sign = 1'b1; e3_mode = 2'd0; settle();
    chk("R8 code0 power fail", pin_e3, 1);
    e3_mode = 2'd1; e1_mode = 2'd2; settle();
    chk("R8 code1 selected sign negative", pin_e3, 1);
    e1_mode = 2'd0; settle();
    chk("R8 code1 selected sign positive", pin_e3, 0);
    for (int k = 2; k < 4; k++) begin
      e3_mode = 2'(k); e1_mode = 2'd1; do_reset(); run(60, 8);
      chk("R8 unused code rises", d3, 0);
      chk("R8 unused code level", pin_e3, 0);
    end

    // R9: steady pins ignore rate, width and strobe
    e1_mode = 2'd0; e2_mode = 2'd2; e3_mode = 2'd1; chan_in_use = 1'b1;
    rate_k = 16'hFFFF; width_n = 8'd7; act_val = 16'h7FFF;
    settle();
    run(60, 8);
    chk("R9 channel pin no edges", d2, 0);
    chk("R9 channel pin level", pin_e2, 1);
    chk("R9 power fail pin no edges", d3, 0);
    chk("R9 power fail pin level", pin_e3, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule